// File: doc/BRIEF.md
# Self-Terminating Pixel Trim Calibrator

This block is the digital half of a per-pixel offset trim loop for a capacitive sensing array. Each pixel owns a small binary trim code whose bits close switches onto binary-weighted capacitor groups. During calibration, with nothing touching the sensor, the pixel's front end emits a sensor pulse whose width grows as more capacitance is added. A reference pulse of fixed width is shared by the whole array. Both pulses start together.

Whenever the reference outlives the sensor pulse, there is a gap in which the reference is still high and the sensor pulse has already ended. Each calibration step that shows such a gap raises the code by one. The first step without a gap ends the search. From then on the code stays as it is until a clear. With a code of n bits, 2^n − 1 steps are enough to reach any code.

Both pulses are synchronized through the same flip-flop chain, so the gap is measured in the clock domain. Each step is closed by the falling edge of the synchronized reference. When the step enable is low (sensing mode), reference pulses are ignored.

Top module: `pix_trim_cal`

## Requirements
- R1: A high `clear_i` at a clock edge sets the trim code to 0 and drops `done_o` at that edge, whatever the other inputs are.
- R2: For a calibration step in which the sensor pulse ends while the reference is still high, the trim code rises by one once the synchronized reference has fallen.
- R3: For a step in which the sensor pulse lasts as long as the reference or longer (equal widths included), the code does not change and `done_o` goes high. After that, further steps leave the code unchanged until a clear.
- R4: The trim code is CODE_W bits wide (3 by default, eight levels). `bank_en_o[i]` enables the group of 2^i unit capacitors and equals code bit i.
- R5: The code saturates at 2^CODE_W − 1 and never wraps. `done_o` goes high in the step that brings the code to that maximum.
- R6: While `step_en_i` is low, reference pulses are ignored and neither the code nor `done_o` changes.
- R7: After 2^CODE_W − 1 steps from a clear, the code equals the smallest value c at which the sensor pulse width is not shorter than the reference width, capped at the maximum, and `done_o` is high.
- R8: After reset the code is 0, all bank enables are off and `done_o` is low.
- R9: A step advances the code by at most one, however wide the gap between the two pulses is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous start strobe: zero the code and restart the search |
| step_en_i | input | 1 | High in calibration mode; low holds the code |
| sense_pulse_i | input | 1 | Pixel sensor pulse; its width encodes the sensed capacitance |
| ref_pulse_i | input | 1 | Shared reference pulse; one pulse is one calibration step |
| trim_code_o | output | CODE_W | Current trim code |
| bank_en_o | output | CODE_W | Switch enable per binary-weighted capacitor group |
| done_o | output | 1 | Search finished (gapless step seen or code saturated) |

## Verification
The bench builds the block with its defaults: CODE_W of 3 and a synchronizer two stages deep. With these values saturation at 7 is reached within a seven-step calibration, and a sensor that grows one cycle per code level against a ten-cycle reference runs into that cap. A behavioural pixel derives its pulse width from the trim code it reads back, which brings within reach the exact-equality stop, stops at intermediate codes and the wrap boundary at 7. A single-cycle sensor pulse gives the widest gap and tests the one-advance-per-step rule.

// File: rtl/pix_trim_cal.sv
module pix_trim_cal #(
  parameter int CODE_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_en_i,
  input  logic              sense_pulse_i,
  input  logic              ref_pulse_i,
  output logic [CODE_W-1:0] trim_code_o,
  output logic [CODE_W-1:0] bank_en_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [SYNC_N-1:0] ref_sync, sns_sync;
  logic              ref_q;
  logic              gap_seen;
  logic [CODE_W-1:0] code_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sync <= '0;
      sns_sync <= '0;
      ref_q    <= 1'b0;
    end else begin
      ref_sync <= {ref_sync[SYNC_N-2:0], ref_pulse_i};
      sns_sync <= {sns_sync[SYNC_N-2:0], sense_pulse_i};
      ref_q    <= ref_sync[SYNC_N-1];
    end
  end

  wire ref_s     = ref_sync[SYNC_N-1];
  wire sns_s     = sns_sync[SYNC_N-1];
  wire gap       = ref_s & ~sns_s;
  wire step_rise = ref_s & ~ref_q;
  wire step_end  = ref_q & ~ref_s;
  wire live      = step_en_i & ~done_q;
  wire [CODE_W-1:0] code_inc = code_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      done_q   <= 1'b0;
      gap_seen <= 1'b0;
    end else if (clear_i) begin
      code_q   <= '0;
      done_q   <= 1'b0;
      gap_seen <= 1'b0;
    end else if (live) begin
      if (step_rise)
        gap_seen <= gap;
      else if (gap)
        gap_seen <= 1'b1;
      if (step_end) begin
        if (gap_seen && code_q != CODE_MAX) begin
          code_q <= code_inc;
          done_q <= (code_inc == CODE_MAX);
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assign trim_code_o = code_q;
  assign bank_en_o   = code_q;
  assign done_o      = done_q;
endmodule

// File: rtl/pix_trim_cal_chk.sv
module pix_trim_cal_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              step_en_i,
  input logic [CODE_W-1:0] trim_code_o,
  input logic [CODE_W-1:0] bank_en_o,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] CMAX = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (trim_code_o == '0) && !done_o); // R1

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && trim_code_o != CMAX) |=> (trim_code_o == $past(trim_code_o)) ||
      (trim_code_o == $past(trim_code_o) + 1'b1)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && trim_code_o == CMAX) |=> trim_code_o == CMAX); // R5

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && done_o) |=> done_o && $stable(trim_code_o)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !step_en_i) |=> $stable(trim_code_o) && $stable(done_o)); // R6

  AST_SAT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && trim_code_o != CMAX) ##1 (trim_code_o == CMAX) |-> done_o); // R5
endmodule

bind pix_trim_cal pix_trim_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .step_en_i(step_en_i),
  .trim_code_o(trim_code_o), .bank_en_o(bank_en_o), .done_o(done_o));

// File: tb/pix_trim_cal_bench.sv
module pix_trim_cal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;
  localparam int REFW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clear_i = 1'b0, step_en_i = 1'b0;
  logic sense_pulse_i = 1'b0, ref_pulse_i = 1'b0;
  logic [CW-1:0] trim_code_o, bank_en_o;
  logic done_o;

  int checks = 0, errors = 0;
  int base_w = 1, gain_w = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_trim_cal #(.CODE_W(CW), .SYNC_N(2)) u_pix_trim_cal (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .step_en_i(step_en_i),
    .sense_pulse_i(sense_pulse_i), .ref_pulse_i(ref_pulse_i),
    .trim_code_o(trim_code_o), .bank_en_o(bank_en_o), .done_o(done_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int target(int b, int g);
    for (int c = 0; c <= CMAX; c++)
      if (b + g * c >= REFW) return c;
    return CMAX;
  endfunction

  task automatic do_clear();
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
  endtask

  task automatic do_step();
    int sw = base_w + gain_w * int'(trim_code_o);
    int last = (sw > REFW) ? sw : REFW;
    @(negedge clk);
    ref_pulse_i = 1'b1;
    sense_pulse_i = 1'b1;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      if (i == sw) sense_pulse_i = 1'b0;
      if (i == REFW) ref_pulse_i = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 code", trim_code_o, 0);
    check("R8 bank", bank_en_o, 0);
    check("R8 done", done_o, 0);
  endtask

  task automatic t_stepwise();
    step_en_i = 1'b1; base_w = 3; gain_w = 2;
    do_clear();
    for (int s = 1; s <= 4; s++) begin
      do_step();
      check("R2 code after gap step", trim_code_o, s);
      check("R4 bank follows code", bank_en_o, s);
      check("R2 done still low", done_o, 0);
    end
    do_step();
    check("R3 code held on gapless step", trim_code_o, 4);
    check("R3 done set", done_o, 1);
    base_w = 1;
    do_step();
    do_step();
    check("R3 frozen after done", trim_code_o, 4);
    do_clear();
    check("R1 clear code", trim_code_o, 0);
    check("R1 clear done", done_o, 0);
  endtask

  task automatic t_equal();
    base_w = REFW; gain_w = 2;
    do_clear();
    do_step();
    check("R3 equal widths no advance", trim_code_o, 0);
    check("R3 equal widths done", done_o, 1);
  endtask

  task automatic t_saturate();
    base_w = 1; gain_w = 1;
    do_clear();
    for (int s = 1; s <= CMAX; s++) begin
      do_step();
      check("R9 one advance per wide-gap step", trim_code_o, s);
    end
    check("R5 done on saturation", done_o, 1);
    check("R4 bank all on", bank_en_o, CMAX);
    do_step();
    check("R5 no wrap", trim_code_o, CMAX);
  endtask

  task automatic t_idle();
    base_w = 1; gain_w = 1;
    do_clear();
    step_en_i = 1'b0;
    do_step();
    do_step();
    check("R6 code held when disabled", trim_code_o, 0);
    check("R6 done held when disabled", done_o, 0);
    step_en_i = 1'b1;
    do_step();
    check("R6 resumes when enabled", trim_code_o, 1);
  endtask

  task automatic t_full();
    step_en_i = 1'b1;
    for (int b = 1; b <= 11; b += 2) begin
      for (int g = 1; g <= 3; g++) begin
        base_w = b; gain_w = g;
        do_clear();
        for (int s = 0; s < CMAX; s++) do_step();
        check("R7 final code", trim_code_o, target(b, g));
        check("R7 done after full run", done_o, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stepwise();
    t_equal();
    t_saturate();
    t_idle();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule